// File: doc/BRIEF.md
# Synchronous SRAM Write-Start and Read-Pipeline Controller

This block sits in front of a single-port synchronous SRAM array of 36-bit words. The array is split into four 9-bit byte lanes and shares one bidirectional data bus for reads and writes. Each clock edge the block decodes the two address strobes, the three chip enables and the write controls. From these it decides whether a new access starts, whether an open access continues at the address supplied by an external burst sequencer, and whether the cycle writes or reads.

A write finishes at the edge that samples it. Only the selected lanes of the word change. A read registers its address at the sampling edge, and the word leaves an output pipeline register one edge later. The block produces the enable for the shared bus drivers. Any write cycle forces that enable off, so a read result is never driven against incoming write data. On every start the block also hands the loaded address to the burst sequencer.

Top module: `sram_wstart_ctl`

## Requirements
- R1: After reset, `dq_oe` and `load_q` are 0 and no access is open. A continuation cycle (both strobes high, `adv_n` low) after reset neither writes nor reads. Reset leaves the array contents unchanged.
- R2: A controller-strobe write occurs when `strobe_ctl_n`=0, `strobe_cpu_n`=1, `ce0_n`=0, `ce1`=1, `ce2_n`=0 and a write is selected. It is stored in the array at that same edge, at `addr_in`.
- R3: If any chip enable is inactive while a strobe is low, nothing is written, and any open access is closed.
- R4: `wr_all_n`=0 stores all four lanes, whatever `wr_en_n` and `lane_wr_n` are. Lane i is data bits [9i+8:9i].
- R5: With `wr_all_n`=1 and `wr_en_n`=0, only lanes with `lane_wr_n[i]`=0 are stored and the other lanes keep their value. With `wr_en_n`=1, or with no lane strobe low, the cycle is a read.
- R6: A start, where either strobe is low with all enables active, makes `load_q`=1 and `base_addr_q`=`addr_in` after the edge. On that cycle `adv_n` is ignored and the access uses `addr_in`, not `burst_addr`.
- R7: When both strobes are low, the processor strobe wins and the access is a read, even with write controls active.
- R8: A read sampled at edge k puts the word on `dq_out` after edge k+1. `dq_oe` is 1 for that one cycle only if `oe_n`=0 and no write is in progress.
- R9: `dq_oe` is 0 in any cycle whose inputs form a write, and whenever `oe_n`=1.
- R10: While an access is open, a cycle with both strobes high and `adv_n`=0 accesses `burst_addr` and writes or reads according to the write controls. With `adv_n`=1, no access takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_in | input | ADDR_W | External word address |
| burst_addr | input | ADDR_W | Next address from burst sequencer |
| strobe_ctl_n | input | 1 | Controller address strobe, active low |
| strobe_cpu_n | input | 1 | Processor address strobe, active low |
| ce0_n | input | 1 | Chip enable, active low |
| ce1 | input | 1 | Chip enable, active high |
| ce2_n | input | 1 | Chip enable, active low |
| adv_n | input | 1 | Advance to burst address, active low |
| wr_all_n | input | 1 | Write all lanes, active low |
| wr_en_n | input | 1 | Lane-write enable, active low |
| lane_wr_n | input | LANES | Per-lane write strobes, active low |
| oe_n | input | 1 | Output enable, active low |
| dq_in | input | LANES*LANE_W | Write data from bus |
| dq_out | output | LANES*LANE_W | Read data to bus |
| dq_oe | output | 1 | Bus driver enable |
| base_addr_q | output | ADDR_W | Address loaded on last start |
| load_q | output | 1 | Pulse: a start was taken |

## Verification
A read whose result reaches the output register can meet a write cycle presented in that same cycle. The output must then be withheld even though output enable is low. The bench issues a processor read, first confirms that the bus is driven in the result cycle, and then presents a controller global write to another address in that cycle. `dq_oe` must fall at once and the written word must read back intact. A similar collision puts both strobes low with write controls active: the bench judges the cycle a read by the data returned and by the unchanged array word.

// File: rtl/sram_wstart_ctl.sv
module sram_wstart_ctl #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        addr_in,
  input  logic [ADDR_W-1:0]        burst_addr,
  input  logic                     strobe_ctl_n,
  input  logic                     strobe_cpu_n,
  input  logic                     ce0_n,
  input  logic                     ce1,
  input  logic                     ce2_n,
  input  logic                     adv_n,
  input  logic                     wr_all_n,
  input  logic                     wr_en_n,
  input  logic [LANES-1:0]         lane_wr_n,
  input  logic                     oe_n,
  input  logic [LANES*LANE_W-1:0]  dq_in,
  output logic [LANES*LANE_W-1:0]  dq_out,
  output logic                     dq_oe,
  output logic [ADDR_W-1:0]        base_addr_q,
  output logic                     load_q
);
  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic              active, rd_v1, out_v;
  logic [ADDR_W-1:0] rd_addr_q;
  logic [DATA_W-1:0] out_q;

  logic              sel, cpu_go, ctl_go, start, desel, cont, wr_now, rd_now;
  logic [LANES-1:0]  lanes;
  logic [ADDR_W-1:0] acc_addr;

  assign sel      = !ce0_n && ce1 && !ce2_n;
  assign cpu_go   = !strobe_cpu_n && sel;
  assign ctl_go   = !strobe_ctl_n && strobe_cpu_n && sel;
  assign start    = cpu_go || ctl_go;
  assign desel    = (!strobe_cpu_n || !strobe_ctl_n) && !sel;
  assign cont     = active && strobe_ctl_n && strobe_cpu_n && !adv_n;
  assign lanes    = !wr_all_n ? {LANES{1'b1}} : (!wr_en_n ? ~lane_wr_n : {LANES{1'b0}});
  assign wr_now   = (ctl_go || cont) && (|lanes);
  assign rd_now   = cpu_go || ((ctl_go || cont) && !(|lanes));
  assign acc_addr = start ? addr_in : burst_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active      <= 1'b0;
      rd_v1       <= 1'b0;
      out_v       <= 1'b0;
      load_q      <= 1'b0;
      rd_addr_q   <= '0;
      base_addr_q <= '0;
    end else begin
      if (start)      active <= 1'b1;
      else if (desel) active <= 1'b0;
      rd_v1  <= rd_now;
      out_v  <= rd_v1;
      load_q <= start;
      if (rd_now) rd_addr_q   <= acc_addr;
      if (start)  base_addr_q <= addr_in;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++)
      if (wr_now && lanes[i])
        mem[acc_addr][i*LANE_W +: LANE_W] <= dq_in[i*LANE_W +: LANE_W];
    if (rd_v1) out_q <= mem[rd_addr_q];
  end

  assign dq_out = out_q;
  assign dq_oe  = out_v && !oe_n && !wr_now;
endmodule

// File: rtl/sram_wstart_ctl_chk.sv
module sram_wstart_ctl_chk #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr_in,
  input logic              strobe_ctl_n,
  input logic              strobe_cpu_n,
  input logic              ce0_n,
  input logic              ce1,
  input logic              ce2_n,
  input logic              adv_n,
  input logic              wr_all_n,
  input logic              wr_en_n,
  input logic [LANES-1:0]  lane_wr_n,
  input logic              oe_n,
  input logic              dq_oe,
  input logic [ADDR_W-1:0] base_addr_q,
  input logic              load_q,
  input logic              active
);
  logic en_p, wreq_p, ctl_p, cpu_p, rd_p;
  assign en_p   = !ce0_n && ce1 && !ce2_n;
  assign wreq_p = !wr_all_n || (!wr_en_n && lane_wr_n != {LANES{1'b1}});
  assign cpu_p  = !strobe_cpu_n && en_p;
  assign ctl_p  = !strobe_ctl_n && strobe_cpu_n && en_p;
  assign rd_p   = cpu_p || ((ctl_p || (active && strobe_ctl_n && strobe_cpu_n && !adv_n)) && !wreq_p);

  assert_wr_tristate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_p && wreq_p) |-> !dq_oe);
  assert_oe_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dq_oe);
  assert_load_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_p || ctl_p) |=> (load_q && base_addr_q == $past(addr_in)));
  assert_no_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_p || ctl_p) |=> !load_q);
  assert_read_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> $past(rd_p, 2));
endmodule

bind sram_wstart_ctl sram_wstart_ctl_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .strobe_ctl_n(strobe_ctl_n),
  .strobe_cpu_n(strobe_cpu_n), .ce0_n(ce0_n), .ce1(ce1), .ce2_n(ce2_n), .adv_n(adv_n),
  .wr_all_n(wr_all_n), .wr_en_n(wr_en_n), .lane_wr_n(lane_wr_n), .oe_n(oe_n),
  .dq_oe(dq_oe), .base_addr_q(base_addr_q), .load_q(load_q), .active(active)
);

// File: tb/tb_sram_wstart_ctl.sv
`timescale 1ns/1ps
module tb_sram_wstart_ctl;
  logic        clk = 0, rst_n = 0;
  logic [5:0]  addr_in = 0, burst_addr = 0, base_addr_q;
  logic        strobe_ctl_n = 1, strobe_cpu_n = 1, ce0_n = 0, ce1 = 1, ce2_n = 0, adv_n = 1;
  logic        wr_all_n = 1, wr_en_n = 1, oe_n = 0, dq_oe, load_q;
  logic [3:0]  lane_wr_n = 4'hF;
  logic [35:0] dq_in = 0, dq_out;
  int errs = 0, nchk = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sram_wstart_ctl dut (.*);

  localparam logic [35:0] BG = 36'h5A5A5A5A5;
  // {wr_all_n, wr_en_n, lane_wr_n[3:0], expected written lanes[3:0]}
  localparam logic [9:0] VEC [8] = '{
    {1'b0, 1'b1, 4'b1111, 4'b1111},
    {1'b0, 1'b0, 4'b1010, 4'b1111},
    {1'b1, 1'b0, 4'b1110, 4'b0001},
    {1'b1, 1'b0, 4'b0101, 4'b1010},
    {1'b1, 1'b0, 4'b0000, 4'b1111},
    {1'b1, 1'b0, 4'b0111, 4'b1000},
    {1'b1, 1'b1, 4'b0000, 4'b0000},
    {1'b1, 1'b0, 4'b1111, 4'b0000}
  };

  task automatic chk(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
    nchk++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    strobe_ctl_n = 1; strobe_cpu_n = 1; adv_n = 1;
    wr_all_n = 1; wr_en_n = 1; lane_wr_n = 4'hF;
    ce0_n = 0; ce1 = 1; ce2_n = 0;
  endtask

  task automatic ctl_acc(input logic [5:0] a, input logic [35:0] d, input logic wa, input logic we,
                         input logic [3:0] ln, input logic adv, input logic [5:0] ba);
    @(negedge clk);
    strobe_ctl_n = 0; addr_in = a; dq_in = d; wr_all_n = wa; wr_en_n = we;
    lane_wr_n = ln; adv_n = adv; burst_addr = ba;
    @(negedge clk);
    idle();
  endtask

  task automatic rd_chk(input logic [5:0] a, input logic [35:0] exp, input string req);
    @(negedge clk);
    strobe_cpu_n = 0; addr_in = a;
    @(negedge clk);
    idle();
    @(negedge clk);
    chk(dq_oe === 1'b1 && dq_out === exp, req, dq_out, exp);
  endtask

  function automatic logic [35:0] merge(input logic [35:0] old, input logic [35:0] nw, input logic [3:0] m);
    merge = old;
    for (int i = 0; i < 4; i++) if (m[i]) merge[i*9 +: 9] = nw[i*9 +: 9];
  endfunction

  initial begin
    idle();
    repeat (2) @(negedge clk);
    chk(dq_oe == 0 && load_q == 0, "R1 reset outputs", {34'b0, dq_oe, load_q}, 36'h0);
    rst_n = 1;

    for (int i = 0; i < 8; i++) begin
      logic [35:0] nd;
      nd = 36'hC3C3C3C3C ^ 36'(i * 36'h111);
      ctl_acc(6'(i), BG, 1'b0, 1'b1, 4'hF, 1'b1, 6'd0);
      ctl_acc(6'(i), nd, VEC[i][9], VEC[i][8], VEC[i][7:4], 1'b1, 6'd0);
      rd_chk(6'(i), merge(BG, nd, VEC[i][3:0]), "R4/R5 lane write");
    end

    ctl_acc(6'd3, 36'h123456789, 1'b0, 1'b1, 4'hF, 1'b1, 6'd0);
    @(negedge clk); strobe_cpu_n = 0; addr_in = 6'd3;
    @(negedge clk); idle();
    @(negedge clk);
    chk(dq_oe === 1'b1 && dq_out === 36'h123456789, "R8 read latency", dq_out, 36'h123456789);
    strobe_ctl_n = 0; addr_in = 6'd5; dq_in = 36'hABCDEF012; wr_all_n = 0;
    #1 chk(dq_oe === 1'b0, "R9 tri-state on write", {35'b0, dq_oe}, 36'h0);
    @(negedge clk); idle();
    rd_chk(6'd5, 36'hABCDEF012, "R2 single-cycle write");

    @(negedge clk); strobe_cpu_n = 0; addr_in = 6'd3;
    @(negedge clk); idle(); oe_n = 1;
    @(negedge clk);
    chk(dq_oe === 1'b0, "R9 oe_n high", {35'b0, dq_oe}, 36'h0);
    oe_n = 0;

    ctl_acc(6'd18, 36'h018018018, 1'b0, 1'b1, 4'hF, 1'b1, 6'd0);
    ctl_acc(6'd40, 36'h040040040, 1'b0, 1'b1, 4'hF, 1'b1, 6'd0);
    ctl_acc(6'd16, 36'h016016016, 1'b0, 1'b1, 4'hF, 1'b0, 6'd40);
    chk(load_q === 1'b1 && base_addr_q === 6'd16, "R6 address load", {30'b0, base_addr_q}, 36'd16);
    strobe_ctl_n = 1; adv_n = 0; burst_addr = 6'd17; wr_all_n = 0; dq_in = 36'h017017017;
    @(negedge clk); adv_n = 1; burst_addr = 6'd18; dq_in = 36'hFFFFFFFFF;
    @(negedge clk); idle();
    rd_chk(6'd16, 36'h016016016, "R6 start address used");
    rd_chk(6'd40, 36'h040040040, "R6 adv_n ignored on start");
    rd_chk(6'd17, 36'h017017017, "R10 continuation write");
    rd_chk(6'd18, 36'h018018018, "R10 no access with adv_n high");

    ctl_acc(6'd20, 36'h020020020, 1'b0, 1'b1, 4'hF, 1'b1, 6'd0);
    ctl_acc(6'd21, 36'h021021021, 1'b0, 1'b1, 4'hF, 1'b1, 6'd0);
    @(negedge clk); strobe_ctl_n = 0; ce1 = 0; addr_in = 6'd20; wr_all_n = 0; dq_in = 36'hDEADDEAD0;
    @(negedge clk); strobe_ctl_n = 1; ce1 = 1; adv_n = 0; burst_addr = 6'd21;
    @(negedge clk); idle();
    rd_chk(6'd20, 36'h020020020, "R3 disabled write blocked");
    rd_chk(6'd21, 36'h021021021, "R3 deselect closes access");

    ctl_acc(6'd24, 36'h024024024, 1'b0, 1'b1, 4'hF, 1'b1, 6'd0);
    @(negedge clk); strobe_cpu_n = 0; strobe_ctl_n = 0; addr_in = 6'd24; wr_all_n = 0; dq_in = 36'hBADBADBAD;
    @(negedge clk); idle();
    @(negedge clk);
    chk(dq_oe === 1'b1 && dq_out === 36'h024024024, "R7 processor strobe read", dq_out, 36'h024024024);
    rd_chk(6'd24, 36'h024024024, "R7 no write on priority");

    ctl_acc(6'd50, 36'h050050050, 1'b0, 1'b1, 4'hF, 1'b1, 6'd0);
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    chk(dq_oe == 0 && load_q == 0, "R1 mid-run reset", {34'b0, dq_oe, load_q}, 36'h0);
    rst_n = 1;
    @(negedge clk); adv_n = 0; burst_addr = 6'd50; wr_all_n = 0; dq_in = 36'h999999999;
    @(negedge clk); idle();
    rd_chk(6'd50, 36'h050050050, "R1 no access after reset");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++; errs++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, nchk);
      $finish;
    end
  end
endmodule